// File: doc/BRIEF.md
# Zero-Cross Gated Stereo Gain Updater

This block sits between a control port and a stereo pair of gain stages. It decides in which clock cycle a newly written 8-bit gain code reaches each channel's active gain output. A normal write parks the code as pending and marks the channel busy. The code goes live on the next rising zero-crossing pulse of that channel's input, or when a cycle-count timeout runs out, whichever happens first. A later write to a busy channel replaces the parked code and starts the timeout again. Instant writes skip the wait. The mute pin and the power-on state follow the same gated path, so no gain jump happens outside a zero crossing or a timeout.

Code 00h means mute. Each code step is 0.5 dB, so FFh is +15.5 dB, E0h is 0 dB and 01h is -111.5 dB. A test-mode flag forces both outputs to 00h and refuses gain writes while it is high. The block also holds two sticky overload flags. A peak pulse sets a flag, and a read strobe of the peak status clears it. The comparators that produce the zero-cross and overload pulses are outside the block. All inputs are synchronous to `clk`.

Top module: `zc_gain_gate`

## Requirements
- R1: After reset both gain outputs are 00h, `busy` is 00 and `ovl_flags` is 00.
- R2: A normal write (`wr_en`=1, `wr_instant`=0) to a channel sets its busy bit after the write edge and leaves its output unchanged. A rising zero-cross pulse of that channel, while it is busy, puts the pending code on the output and clears the busy bit at the same edge.
- R3: If no zero-cross pulse arrives, the pending code is applied exactly TIMEOUT_CYC clock edges after the edge that armed the channel. A channel is never busy for more than TIMEOUT_CYC cycles.
- R4: A normal write to a busy channel replaces the pending code and restarts the timeout. The replaced code never reaches the output.
- R5: An instant write (`wr_instant`=1) puts the code on the output at the write edge and leaves that channel not busy.
- R6: `wr_sel` bit 1 selects the left channel and bit 0 the right channel. Value 11 writes both channels. `busy` and `ovl_flags` use the same order: bit 1 is left, bit 0 is right.
- R7: When `mute_n` falls, both channels arm with code 00h. When it rises, both channels arm with their last written codes. In both cases the change is applied through the zero-cross or timeout path.
- R8: From power-on the outputs stay at 00h whatever the level of `mute_n`. A channel becomes non-zero only after a non-zero code is written and `mute_n` is high. A code written while `mute_n` is low is remembered.
- R9: While `test_mode` is high both outputs read 00h and gain writes are ignored. When `test_mode` drops, the codes from before the test period reappear.
- R10: An overload pulse sets its flag, and the flag stays set until a cycle with `pk_rd` high. If an overload pulse and `pk_rd` come in the same cycle, the flag is still set afterwards.
- R11: A zero-cross pulse on a channel that is not busy, or on the other channel, changes neither output nor busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle gain write strobe |
| wr_sel | input | 2 | Channel select: bit 1 left, bit 0 right |
| wr_instant | input | 1 | 1 = instant write, 0 = gated write |
| wr_code | input | GAIN_W | Gain code to write |
| zc_left | input | 1 | Rising zero-cross pulse, left input |
| zc_right | input | 1 | Rising zero-cross pulse, right input |
| mute_n | input | 1 | Mute pin, low mutes both channels |
| test_mode | input | 1 | Test mode: outputs muted, writes refused |
| ovl_left | input | 1 | Left positive-peak overload pulse |
| ovl_right | input | 1 | Right positive-peak overload pulse |
| pk_rd | input | 1 | Peak status read strobe, clears flags |
| gain_left | output | GAIN_W | Applied left gain code |
| gain_right | output | GAIN_W | Applied right gain code |
| busy | output | 2 | Pending-change flags: bit 1 left, bit 0 right |
| ovl_flags | output | 2 | Sticky overload flags: bit 1 left, bit 0 right |

## Verification
The bench builds the block with TIMEOUT_CYC = 20 and the default GAIN_W of 8. The default timeout is the 22 ms span in 50 MHz cycles. The short timeout makes the last pending cycle and the timeout edge reachable in a few dozen cycles. It also makes it practical to show that a rewrite after ten cycles moves the apply edge out to twenty cycles after the second write. The real 8-bit width lets the bench use the real mute, unity and full-scale codes.

// File: rtl/zcg_pkg.sv
package zcg_pkg;

  localparam int unsigned CH_L = 1;
  localparam int unsigned CH_R = 0;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_INSTANT,
    ACT_ARM,
    ACT_APPLY,
    ACT_COUNT
  } lane_act_e;

  // Priority: instant write, then arming (write or mute edge), then apply.
  function automatic lane_act_e pick_act(input logic inst, input logic arm,
                                         input logic busy, input logic zc,
                                         input logic tmo);
    if (inst) return ACT_INSTANT;
    if (arm) return ACT_ARM;
    if (busy && (zc || tmo)) return ACT_APPLY;
    if (busy) return ACT_COUNT;
    return ACT_HOLD;
  endfunction

endpackage

// File: rtl/zcg_lane.sv
module zcg_lane
  import zcg_pkg::*;
#(
  parameter int unsigned GAIN_W      = 8,
  parameter int unsigned TIMEOUT_CYC = 1100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_norm,
  input  logic              wr_inst,
  input  logic [GAIN_W-1:0] code,
  input  logic              mute_n,
  input  logic              mute_edge,
  input  logic              zc,
  input  logic              test_mode,
  output logic [GAIN_W-1:0] gain_o,
  output logic              busy_o,
  output logic              arm_ev,
  output logic              apply_ev
);

  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  function automatic logic [GAIN_W-1:0] live_code(input logic pin_n,
                                                  input logic [GAIN_W-1:0] c);
    return pin_n ? c : '0;
  endfunction

  logic [GAIN_W-1:0] stored_q, pend_q, applied_q;
  logic [CW-1:0]     cnt_q;
  logic              busy_q;
  logic              tmo_hit;
  lane_act_e         act;

  assign tmo_hit  = (cnt_q == LAST);
  assign act      = pick_act(wr_inst, wr_norm | mute_edge, busy_q, zc, tmo_hit);
  assign arm_ev   = (act == ACT_ARM);
  assign apply_ev = (act == ACT_APPLY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored_q  <= '0;
      pend_q    <= '0;
      applied_q <= '0;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
    end else begin
      if (wr_norm || wr_inst) stored_q <= code;
      unique case (act)
        ACT_INSTANT: begin
          applied_q <= live_code(mute_n, code);
          busy_q    <= 1'b0;
          cnt_q     <= '0;
        end
        ACT_ARM: begin
          pend_q <= live_code(mute_n, wr_norm ? code : stored_q);
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
        ACT_APPLY: begin
          applied_q <= pend_q;
          busy_q    <= 1'b0;
          cnt_q     <= '0;
        end
        ACT_COUNT: cnt_q <= cnt_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign gain_o = test_mode ? '0 : applied_q;
  assign busy_o = busy_q;

endmodule

// File: rtl/zcg_peak.sv
module zcg_peak #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         rd,
  output logic [N-1:0] flags
);

  logic [N-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else flags_q <= (rd ? '0 : flags_q) | hit;
  end

  assign flags = flags_q;

endmodule

// File: rtl/zc_gain_gate.sv
module zc_gain_gate
  import zcg_pkg::*;
#(
  parameter int unsigned GAIN_W      = 8,
  parameter int unsigned TIMEOUT_CYC = 1100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic              wr_instant,
  input  logic [GAIN_W-1:0] wr_code,
  input  logic              zc_left,
  input  logic              zc_right,
  input  logic              mute_n,
  input  logic              test_mode,
  input  logic              ovl_left,
  input  logic              ovl_right,
  input  logic              pk_rd,
  output logic [GAIN_W-1:0] gain_left,
  output logic [GAIN_W-1:0] gain_right,
  output logic [1:0]        busy,
  output logic [1:0]        ovl_flags
);

  logic              mute_q;
  logic              mute_edge;
  logic              wr_ok;
  logic [1:0]        zc_v;
  logic [1:0]        arm_ev;
  logic [1:0]        apply_ev;
  logic [GAIN_W-1:0] gain_v [2];

  // Reset loads the pin level so that leaving reset is not an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) mute_q <= mute_n;
    else mute_q <= mute_n;
  end

  assign mute_edge = mute_n ^ mute_q;
  assign wr_ok     = wr_en && !test_mode;
  assign zc_v      = {zc_left, zc_right};

  for (genvar i = 0; i < 2; i++) begin : g_lane
    zcg_lane #(
      .GAIN_W     (GAIN_W),
      .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_norm  (wr_ok && wr_sel[i] && !wr_instant),
      .wr_inst  (wr_ok && wr_sel[i] && wr_instant),
      .code     (wr_code),
      .mute_n   (mute_n),
      .mute_edge(mute_edge),
      .zc       (zc_v[i]),
      .test_mode(test_mode),
      .gain_o   (gain_v[i]),
      .busy_o   (busy[i]),
      .arm_ev   (arm_ev[i]),
      .apply_ev (apply_ev[i])
    );
  end

  assign gain_left  = gain_v[CH_L];
  assign gain_right = gain_v[CH_R];

  zcg_peak #(.N(2)) u_peak (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  ({ovl_left, ovl_right}),
    .rd   (pk_rd),
    .flags(ovl_flags)
  );

endmodule

// File: rtl/zcg_chk.sv
module zcg_chk #(
  parameter int unsigned GAIN_W      = 8,
  parameter int unsigned TIMEOUT_CYC = 1100000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic              wr_instant,
  input logic              test_mode,
  input logic              ovl_left,
  input logic              ovl_right,
  input logic              pk_rd,
  input logic [GAIN_W-1:0] gain_left,
  input logic [GAIN_W-1:0] gain_right,
  input logic [1:0]        busy,
  input logic [1:0]        ovl_flags,
  input logic [1:0]        arm_ev,
  input logic [1:0]        apply_ev
);

  int unsigned wait_l, wait_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_l <= 0;
      wait_r <= 0;
    end else begin
      wait_l <= arm_ev[1] ? 0 : (busy[1] ? wait_l + 1 : 0);
      wait_r <= arm_ev[0] ? 0 : (busy[0] ? wait_r + 1 : 0);
    end
  end

  p_tmo_bound_l_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy[1] |-> wait_l < TIMEOUT_CYC);
  p_tmo_bound_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy[0] |-> wait_r < TIMEOUT_CYC);

  p_arm_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_instant && !test_mode && wr_sel[1]) |=> busy[1]);

  p_apply_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    apply_ev[1] |=> !busy[1]);

  p_gain_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(test_mode) && !$past(wr_en) && !$past(apply_ev[1]))
      |-> $stable(gain_left));

  p_instant_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_instant && !test_mode && wr_sel[0]) |=> !busy[0]);

  p_test_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> (gain_left == '0 && gain_right == '0));

  p_ovl_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_left |=> ovl_flags[1]);

  p_ovl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_flags[0] && !pk_rd) |=> ovl_flags[0]);

endmodule

bind zc_gain_gate zcg_chk #(
  .GAIN_W     (GAIN_W),
  .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_instant(wr_instant),
  .test_mode (test_mode),
  .ovl_left  (ovl_left),
  .ovl_right (ovl_right),
  .pk_rd     (pk_rd),
  .gain_left (gain_left),
  .gain_right(gain_right),
  .busy      (busy),
  .ovl_flags (ovl_flags),
  .arm_ev    (arm_ev),
  .apply_ev  (apply_ev)
);

// File: tb/test_zc_gain_gate.sv
module test_zc_gain_gate;

  localparam int LIM = 20;

  localparam logic [2:0] OP_WN = 3'd0;  // gated write
  localparam logic [2:0] OP_WI = 3'd1;  // instant write
  localparam logic [2:0] OP_ZC = 3'd2;  // zero-cross pulse on sel
  localparam logic [2:0] OP_TO = 3'd3;  // wait out the timeout

  typedef struct packed {
    logic [2:0] op;
    logic [1:0] sel;
    logic [7:0] code;
    logic [7:0] gl;
    logic [7:0] gr;
    logic [1:0] bz;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{OP_WN, 2'b10, 8'hC0, 8'h00, 8'h00, 2'b10},  // R2 arm left
    '{OP_ZC, 2'b10, 8'h00, 8'hC0, 8'h00, 2'b00},  // R2 zc applies
    '{OP_WN, 2'b01, 8'h80, 8'hC0, 8'h00, 2'b01},  // R6 right bit 0
    '{OP_ZC, 2'b10, 8'h00, 8'hC0, 8'h00, 2'b01},  // R11 other channel zc
    '{OP_TO, 2'b00, 8'h00, 8'hC0, 8'h80, 2'b00},  // R3 timeout applies
    '{OP_WN, 2'b11, 8'h40, 8'hC0, 8'h80, 2'b11},  // R6 both
    '{OP_ZC, 2'b01, 8'h00, 8'hC0, 8'h40, 2'b10},  // R6 right only
    '{OP_ZC, 2'b10, 8'h00, 8'h40, 8'h40, 2'b00},  // R6 left
    '{OP_WI, 2'b10, 8'hFF, 8'hFF, 8'h40, 2'b00},  // R5 instant
    '{OP_WN, 2'b10, 8'h10, 8'hFF, 8'h40, 2'b10},  // R4 first
    '{OP_WN, 2'b10, 8'h20, 8'hFF, 8'h40, 2'b10},  // R4 overwrite
    '{OP_ZC, 2'b10, 8'h00, 8'h20, 8'h40, 2'b00},  // R4 only newest
    '{OP_WI, 2'b11, 8'h01, 8'h01, 8'h01, 2'b00},  // R5 instant both
    '{OP_ZC, 2'b11, 8'h00, 8'h01, 8'h01, 2'b00}   // R11 idle zc
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_instant = 1'b0;
  logic [1:0] wr_sel = 2'b00;
  logic [7:0] wr_code = 8'h00;
  logic       zc_left = 1'b0, zc_right = 1'b0;
  logic       mute_n = 1'b1, test_mode = 1'b0;
  logic       ovl_left = 1'b0, ovl_right = 1'b0, pk_rd = 1'b0;
  logic [7:0] gain_left, gain_right;
  logic [1:0] busy, ovl_flags;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  zc_gain_gate #(.GAIN_W(8), .TIMEOUT_CYC(LIM)) i_zc_gain_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_instant(wr_instant), .wr_code(wr_code), .zc_left(zc_left),
    .zc_right(zc_right), .mute_n(mute_n), .test_mode(test_mode),
    .ovl_left(ovl_left), .ovl_right(ovl_right), .pk_rd(pk_rd),
    .gain_left(gain_left), .gain_right(gain_right), .busy(busy),
    .ovl_flags(ovl_flags)
  );

  task automatic chk(input string req, input logic [17:0] exp);
    logic [17:0] act;
    act = {gain_left, gain_right, busy};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got gl=%h gr=%h busy=%b, want gl=%h gr=%h busy=%b",
               req, act[17:10], act[9:2], act[1:0], exp[17:10], exp[9:2], exp[1:0]);
    end
  endtask

  task automatic chk_flags(input string req, input logic [1:0] exp);
    checks++;
    if (ovl_flags !== exp) begin
      errors++;
      $display("FAIL %s: ovl_flags=%b want %b", req, ovl_flags, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Drive for one cycle; the caller samples at the following negedge.
  task automatic write(input logic inst, input logic [1:0] sel, input logic [7:0] c);
    wr_en = 1'b1; wr_instant = inst; wr_sel = sel; wr_code = c;
    @(negedge clk);
    wr_en = 1'b0; wr_instant = 1'b0; wr_sel = 2'b00;
  endtask

  task automatic zc(input logic [1:0] sel);
    zc_left = sel[1]; zc_right = sel[0];
    @(negedge clk);
    zc_left = 1'b0; zc_right = 1'b0;
  endtask

  task automatic do_reset(input logic pin);
    rst_n = 1'b0; mute_n = pin;
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, got timeout want finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1'b1);
    @(negedge clk);
    chk("R1 reset gains/busy", {8'h00, 8'h00, 2'b00});
    chk_flags("R1 reset flags", 2'b00);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v].op)
        OP_WN: write(1'b0, VEC[v].sel, VEC[v].code);
        OP_WI: write(1'b1, VEC[v].sel, VEC[v].code);
        OP_ZC: zc(VEC[v].sel);
        default: idle(LIM);
      endcase
      chk($sformatf("R2-table step %0d", v), {VEC[v].gl, VEC[v].gr, VEC[v].bz});
    end

    // R7 mute entry: falling pin arms both with 00h
    mute_n = 1'b0;
    @(negedge clk);
    chk("R7 mute arms both", {8'h01, 8'h01, 2'b11});
    zc(2'b10);
    chk("R7 left muted at zc", {8'h00, 8'h01, 2'b01});
    idle(LIM - 1);
    chk("R7 right muted at timeout", {8'h00, 8'h00, 2'b00});
    mute_n = 1'b1;
    @(negedge clk);
    chk("R7 unmute arms both", {8'h00, 8'h00, 2'b11});
    zc(2'b11);
    chk("R7 unmute restores", {8'h01, 8'h01, 2'b00});

    // R3 exact timeout edge
    write(1'b0, 2'b01, 8'h33);
    idle(LIM - 1);
    chk("R3 one cycle before timeout", {8'h01, 8'h01, 2'b01});
    idle(1);
    chk("R3 at timeout", {8'h01, 8'h33, 2'b00});

    // R4 rewrite restarts the timer
    write(1'b0, 2'b10, 8'h50);
    idle(10);
    write(1'b0, 2'b10, 8'h60);
    idle(LIM - 1);
    chk("R4 timer restarted", {8'h01, 8'h33, 2'b10});
    idle(1);
    chk("R4 newest applied", {8'h60, 8'h33, 2'b00});

    // R9 test mode
    test_mode = 1'b1;
    @(negedge clk);
    chk("R9 outputs muted", {8'h00, 8'h00, 2'b00});
    write(1'b1, 2'b10, 8'hAA);
    write(1'b0, 2'b01, 8'hAA);
    chk("R9 writes refused", {8'h00, 8'h00, 2'b00});
    test_mode = 1'b0;
    @(negedge clk);
    chk("R9 codes return", {8'h60, 8'h33, 2'b00});

    // R10 overload flags
    ovl_left = 1'b1; @(negedge clk); ovl_left = 1'b0;
    chk_flags("R10 left set", 2'b10);
    idle(2);
    chk_flags("R10 sticky", 2'b10);
    pk_rd = 1'b1; @(negedge clk); pk_rd = 1'b0;
    chk_flags("R10 cleared by read", 2'b00);
    pk_rd = 1'b1; ovl_right = 1'b1; @(negedge clk);
    pk_rd = 1'b0; ovl_right = 1'b0;
    chk_flags("R10 pulse wins over read", 2'b01);
    pk_rd = 1'b1; @(negedge clk); pk_rd = 1'b0;
    chk_flags("R10 second read clears", 2'b00);

    // R8 power-on mute with pin low
    do_reset(1'b0);
    write(1'b0, 2'b10, 8'h70);
    chk("R8 write while muted arms", {8'h00, 8'h00, 2'b10});
    idle(LIM);
    chk("R8 stays muted", {8'h00, 8'h00, 2'b00});
    mute_n = 1'b1;
    @(negedge clk);
    idle(LIM);
    chk("R8 release applies remembered code", {8'h70, 8'h00, 2'b00});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule